// File: doc/BRIEF.md
# Bus Service Request Priority Arbiter

This block shares one bus among six requesters on a fixed-priority basis. There are two direct data transfer requests, one from bus master modules and one from the processor's program and data fetch path, and four interrupt levels. When the arbiter is idle and not inhibited, it samples every unmasked request line at once into a capture register. In the next cycle it raises a one-cycle service strobe.

A fixed number of clock cycles after the strobe, the arbiter drives a one-hot select for the highest-ranked captured source. The delay stands for a settling time of about 20 ns and defaults to 2 cycles. The select holds until the consumer signals completion. The arbiter then returns to idle and samples again at the next clock edge.

Interrupt levels can be masked one at a time. Reset empties the mask, the capture register and the busy state, and then reports completion with a one-cycle pulse.

Top module: `svc_req_arbiter`

## Requirements
- R1: While `rst` is high, `grant_sel` is 0, `svc_strobe` is 0 and `reset_done` is 0. `reset_done` is high for exactly one cycle: the cycle that follows the first clock edge at which `rst` is sampled low.
- R2: A clock edge that finds the arbiter idle, `inhibit` low and at least one eligible request captures all eligible requests. `svc_strobe` is then high for exactly the one cycle after that edge.
- R3: The six sources rank, from highest to lowest: master transfer, interrupt level 4, 3, 2, 1, processor transfer. `grant_sel` bit 5 is the master transfer, bit L (L = 1 to 4) is interrupt level L, and bit 0 is the processor transfer. `grant_sel` never has more than one bit set.
- R4: When the master transfer request is among the captured requests, `grant_sel` is exactly 6'b100000, whatever else was captured.
- R5: `grant_sel` stays 0 during the strobe cycle and the SETTLE_CYC-1 cycles after it. It becomes the winner exactly SETTLE_CYC cycles after the strobe cycle.
- R6: `grant_sel` holds its value until `done` is sampled high. It is 0 in the cycle after that edge. A request still present is captured at the next edge after that.
- R7: A cycle with `irq_mask_wr` high loads `irq_mask_in` into the mask. Mask bit i = 1 blocks interrupt level i+1 from capture. A request made only of masked levels produces no strobe and no select. The mask never affects the two transfer requests.
- R8: While `inhibit` is high, no capture occurs. `no_irq_req` is high whenever `inhibit` is high or the arbiter is not idle (settling or granting), and low otherwise.
- R9: Requests that change after capture do not alter the select issued for that capture.
- R10: Reset during a grant drops `grant_sel` and clears the mask, so a level that was masked before the reset can win afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_master_ddt | input | 1 | Transfer request from bus master modules (top rank) |
| req_irq | input | 4 | Interrupt requests, bit i = level i+1 |
| req_cpu_ddt | input | 1 | Processor program/data transfer request (bottom rank) |
| irq_mask_wr | input | 1 | Load enable for the interrupt mask |
| irq_mask_in | input | 4 | New mask value, bit i = 1 blocks level i+1 |
| inhibit | input | 1 | Blocks new capture while high |
| done | input | 1 | Ends the current grant |
| svc_strobe | output | 1 | One-cycle pulse after a capture |
| grant_sel | output | 6 | One-hot select of the winning source |
| no_irq_req | output | 1 | High while busy or inhibited |
| reset_done | output | 1 | One-cycle pulse after reset is released |

## Verification
The hardest states to reach from the ports involve requests that move inside the capture-to-grant window. In one, a higher-ranked request appears after capture but before the select; in another, reset arrives while a select is held under a non-empty mask. The stimulus is aligned to the observed strobe. A master request is raised in the strobe cycle, and the bench confirms that the lower-ranked captured level still wins and that the master is served by the next capture. Reset is applied once the select is visible, and the bench then offers a level that was masked before the reset.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;

    localparam int NUM_IRQ = 4;
    localparam int NUM_SRC = NUM_IRQ + 2;

    // Packed so that bit position equals rank: MSB is the top source.
    typedef struct packed {
        logic               master_ddt;
        logic [NUM_IRQ-1:0] irq;
        logic               cpu_ddt;
    } src_vec_t;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_SETTLE = 2'd1,
        ARB_GRANT  = 2'd2
    } arb_state_t;

    localparam logic [NUM_SRC-1:0] MASTER_ONEHOT = NUM_SRC'(1) << (NUM_SRC - 1);

    function automatic src_vec_t apply_mask(input src_vec_t raw,
                                            input logic [NUM_IRQ-1:0] blk);
        src_vec_t v;
        v     = raw;
        v.irq = raw.irq & ~blk;
        return v;
    endfunction

    function automatic logic any_src(input src_vec_t v);
        return |v;
    endfunction

endpackage

// File: rtl/svc_req_capture.sv
module svc_req_capture
    import svc_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mask_wr,
    input  logic [NUM_IRQ-1:0] mask_in,
    input  src_vec_t           raw_req,
    input  logic               load,
    input  logic               clear,
    output src_vec_t           eligible,
    output src_vec_t           cap_q
);

    logic [NUM_IRQ-1:0] mask_q;

    always_comb begin
        eligible = apply_mask(raw_req, mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            cap_q  <= '0;
        end else begin
            if (mask_wr) begin
                mask_q <= mask_in;
            end
            if (load) begin
                cap_q <= eligible;
            end else if (clear) begin
                cap_q <= '0;
            end
        end
    end

    AST_MASKED_NOT_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        load |=> ((cap_q.irq & $past(mask_q)) == '0)); // R7

endmodule

// File: rtl/svc_prio_resolve.sv
module svc_prio_resolve
    import svc_arb_pkg::*;
(
    input  src_vec_t           req,
    output logic [NUM_SRC-1:0] win
);

    logic [NUM_SRC-1:0] flat;

    assign flat = req;

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_rank
            if (i == NUM_SRC - 1) begin : g_top
                assign win[i] = flat[i];
            end else begin : g_lower
                assign win[i] = flat[i] & ~(|flat[NUM_SRC-1:i+1]);
            end
        end
    endgenerate

endmodule

// File: rtl/svc_settle_timer.sv
module svc_settle_timer #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic fire
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign fire = active && (cnt == LAST);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= LAST)); // R5
    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire); // R5

endmodule

// File: rtl/svc_reset_seq.sv
module svc_reset_seq (
    input  logic clk,
    input  logic rst,
    output logic reset_done
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b1;
            reset_done <= 1'b0;
        end else begin
            reset_done <= pend;
            pend       <= 1'b0;
        end
    end

    AST_RESET_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reset_done |=> !reset_done); // R1
    AST_RESET_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> reset_done); // R1

endmodule

// File: rtl/svc_req_arbiter.sv
module svc_req_arbiter
    import svc_arb_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_master_ddt,
    input  logic [NUM_IRQ-1:0] req_irq,
    input  logic               req_cpu_ddt,
    input  logic               irq_mask_wr,
    input  logic [NUM_IRQ-1:0] irq_mask_in,
    input  logic               inhibit,
    input  logic               done,
    output logic               svc_strobe,
    output logic [NUM_SRC-1:0] grant_sel,
    output logic               no_irq_req,
    output logic               reset_done
);

    arb_state_t         state;
    src_vec_t           raw_req;
    src_vec_t           eligible;
    src_vec_t           cap_q;
    logic [NUM_SRC-1:0] win;
    logic               load;
    logic               clear;
    logic               fire;

    always_comb begin
        raw_req.master_ddt = req_master_ddt;
        raw_req.irq        = req_irq;
        raw_req.cpu_ddt    = req_cpu_ddt;
    end

    assign load  = (state == ARB_IDLE) && !inhibit && any_src(eligible);
    assign clear = (state == ARB_GRANT) && done;

    svc_req_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .mask_wr  (irq_mask_wr),
        .mask_in  (irq_mask_in),
        .raw_req  (raw_req),
        .load     (load),
        .clear    (clear),
        .eligible (eligible),
        .cap_q    (cap_q)
    );

    svc_prio_resolve u_resolve (
        .req (cap_q),
        .win (win)
    );

    svc_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (load),
        .fire  (fire)
    );

    svc_reset_seq u_rstseq (
        .clk        (clk),
        .rst        (rst),
        .reset_done (reset_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ARB_IDLE;
            svc_strobe <= 1'b0;
            grant_sel  <= '0;
        end else begin
            svc_strobe <= load;
            unique case (state)
                ARB_IDLE: begin
                    if (load) begin
                        state <= ARB_SETTLE;
                    end
                end
                ARB_SETTLE: begin
                    if (fire) begin
                        state     <= ARB_GRANT;
                        grant_sel <= win;
                    end
                end
                ARB_GRANT: begin
                    if (done) begin
                        state     <= ARB_IDLE;
                        grant_sel <= '0;
                    end
                end
                default: begin
                    state <= ARB_IDLE;
                end
            endcase
        end
    end

    assign no_irq_req = (state != ARB_IDLE) || inhibit;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_sel)); // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        svc_strobe |=> !svc_strobe); // R2
    AST_MASTER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (fire && cap_q.master_ddt) |=> (grant_sel == MASTER_ONEHOT)); // R4
    AST_SEL_QUIET_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
        svc_strobe |-> (grant_sel == '0)); // R5
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((|grant_sel) && !done) |=> (grant_sel == $past(grant_sel))); // R6
    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((|grant_sel) && done) |=> (grant_sel == '0)); // R6
    AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> !svc_strobe); // R8

endmodule

// File: tb/tb_svc_req_arbiter.sv
module tb_svc_req_arbiter;

    localparam int SETTLE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_m = 1'b0;
    logic [3:0] req_i = '0;
    logic       req_c = 1'b0;
    logic       mwr = 1'b0;
    logic [3:0] min = '0;
    logic       inhibit = 1'b0;
    logic       done = 1'b0;
    logic       svc_strobe;
    logic [5:0] grant_sel;
    logic       no_irq_req;
    logic       reset_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    svc_req_arbiter #(.SETTLE_CYC(SETTLE)) dut (
        .clk            (clk),
        .rst            (rst),
        .req_master_ddt (req_m),
        .req_irq        (req_i),
        .req_cpu_ddt    (req_c),
        .irq_mask_wr    (mwr),
        .irq_mask_in    (min),
        .inhibit        (inhibit),
        .done           (done),
        .svc_strobe     (svc_strobe),
        .grant_sel      (grant_sel),
        .no_irq_req     (no_irq_req),
        .reset_done     (reset_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [5:0] v);
        req_m = v[5];
        req_i = v[4:1];
        req_c = v[0];
    endtask

    task automatic set_mask(input logic [3:0] m);
        @(negedge clk); mwr = 1'b1; min = m;
        @(negedge clk); mwr = 1'b0;
    endtask

    // wait from strobe cycle to select, checking quiet cycles (R5)
    task automatic wait_select(input logic [5:0] exp, input string tag);
        for (int k = 1; k < SETTLE; k++) begin
            @(negedge clk);
            chk({tag, " R5 quiet"}, grant_sel, 6'h00);
            chk({tag, " R8 busy"}, no_irq_req, 1'b1);
        end
        @(negedge clk);
        chk({tag, " select"}, grant_sel, exp);
    endtask

    task automatic finish_grant(input logic [5:0] exp, input string tag);
        @(negedge clk);
        chk({tag, " R6 hold"}, grant_sel, exp);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk({tag, " R6 release"}, grant_sel, 6'h00);
    endtask

    task automatic run_grant(input logic [5:0] v, input logic [5:0] exp, input string tag);
        @(negedge clk); set_req(v);
        @(negedge clk);
        chk({tag, " R2 strobe"}, svc_strobe, 1'b1);
        chk({tag, " R5 no sel at strobe"}, grant_sel, 6'h00);
        set_req(6'h00);
        wait_select(exp, tag);
        finish_grant(exp, tag);
        @(negedge clk);
        chk({tag, " R8 idle flag"}, no_irq_req, 1'b0);
    endtask

    task automatic expect_no_capture(input logic [5:0] v, input string tag);
        @(negedge clk); set_req(v);
        repeat (3) begin
            @(negedge clk);
            chk({tag, " no strobe"}, svc_strobe, 1'b0);
            chk({tag, " no sel"}, grant_sel, 6'h00);
        end
        set_req(6'h00);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 sel in reset", grant_sel, 6'h00);
        chk("R1 strobe in reset", svc_strobe, 1'b0);
        chk("R1 done low in reset", reset_done, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done pulse", reset_done, 1'b1);
        @(negedge clk);
        chk("R1 done single", reset_done, 1'b0);
        chk("R8 idle after reset", no_irq_req, 1'b0);
    endtask

    task automatic t_priority;
        run_grant(6'h3F, 6'h20, "R4 all six");
        run_grant(6'h21, 6'h20, "R4 master over cpu");
        run_grant(6'h13, 6'h10, "R3 lvl4 over lvl1 cpu");
        run_grant(6'h0D, 6'h08, "R3 lvl3 over lvl2 cpu");
        run_grant(6'h06, 6'h04, "R3 lvl2 over lvl1");
        run_grant(6'h03, 6'h02, "R3 lvl1 over cpu");
        run_grant(6'h01, 6'h01, "R3 cpu alone");
    endtask

    task automatic t_mask;
        set_mask(4'b0001);
        expect_no_capture(6'h02, "R7 lvl1 masked");
        run_grant(6'h03, 6'h01, "R7 masked lvl1 cpu wins");
        set_mask(4'b1000);
        run_grant(6'h14, 6'h04, "R7 masked lvl4 lvl2 wins");
        set_mask(4'b1111);
        run_grant(6'h21, 6'h20, "R7 master unaffected");
        run_grant(6'h1F, 6'h01, "R7 cpu unaffected");
        set_mask(4'b0000);
    endtask

    task automatic t_inhibit;
        @(negedge clk); inhibit = 1'b1; set_req(6'h08);
        repeat (3) begin
            @(negedge clk);
            chk("R8 inhibit no strobe", svc_strobe, 1'b0);
            chk("R8 inhibit flag", no_irq_req, 1'b1);
        end
        inhibit = 1'b0;
        @(negedge clk);
        chk("R8 capture after inhibit", svc_strobe, 1'b1);
        set_req(6'h00);
        wait_select(6'h08, "R8 inhibit release");
        finish_grant(6'h08, "R8 inhibit release");
    endtask

    task automatic t_latched;
        @(negedge clk); set_req(6'h02);
        @(negedge clk);
        chk("R9 strobe", svc_strobe, 1'b1);
        set_req(6'h20);
        wait_select(6'h02, "R9 late master");
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R6 release before resample", grant_sel, 6'h00);
        @(negedge clk);
        chk("R6 resample strobe", svc_strobe, 1'b1);
        set_req(6'h00);
        wait_select(6'h20, "R6 resampled master");
        finish_grant(6'h20, "R6 resampled master");
    endtask

    task automatic t_reset_mid;
        set_mask(4'b0010);
        expect_no_capture(6'h04, "R7 lvl2 masked");
        @(negedge clk); set_req(6'h10);
        @(negedge clk); set_req(6'h00);
        wait_select(6'h10, "R10 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R10 sel dropped", grant_sel, 6'h00);
        chk("R10 strobe low", svc_strobe, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset done", reset_done, 1'b1);
        run_grant(6'h04, 6'h04, "R10 mask cleared");
    endtask

    initial begin
        t_reset();
        t_priority();
        t_mask();
        t_inhibit();
        t_latched();
        t_reset_mid();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule